// File: doc/BRIEF.md
# PCI Initiator Fatal and Parity Error Handler

This block sits beside the initiator engine of a bridge that turns requests arriving at a system-bus slave port into PCI transactions. It watches the current PCI request for four fatal outcomes: master abort, target abort, a target that has claimed the cycle but keeps the data phase waiting too long, and too many retry terminations. When one of these occurs, it applies a response that depends on the direction of the transfer. A failed read that the system-bus master is still waiting for gets an ERROR response. A read that failed during read-ahead is not reported on the bus. A failed write is never reported on the bus. Instead it empties both the request queue and the transmit-data queue, and any write burst still arriving is absorbed and completes normally.

Parity problems are treated as non-fatal. Bad read parity, or PERR raised by the target of a write, only sets sticky status bits, and the transfer carries on. After any fatal error the slave port is barred from starting further PCI requests. The bar lifts only when software clears the fatal status bit with a write-one-to-clear.

Top module: `pci_init_err_guard`

## Requirements
- R1: After reset, every output of the block is low: the bus error strobe, both flush strobes, the write-drop flag, the request gate and all five status bits.
- R2: A master abort or a target abort during an active request sets the sticky fatal bit on the next clock edge. It also sets the sticky master-abort bit or the sticky target-abort bit respectively.
- R3: A fatal error on a read raises `bus_err_resp` for exactly one cycle if `rd_pending` was high when the error occurred. If `rd_pending` was low (a read-ahead), it raises nothing.
- R4: A fatal error on a write pulses `reqq_flush` and `txq_flush` together for one cycle and never raises `bus_err_resp`.
- R5: If `wr_burst_active` is high when a write fails, `wr_drop` rises with the flushes and stays high until `wr_burst_active` falls.
- R6: A TRDY timeout is fatal on the Nth consecutive cycle in which DEVSEL is high, TRDY is low and no target abort is signalled, where N = `cfg_trdy_limit`. The wait count restarts when TRDY is seen or when a new request starts.
- R7: A retry timeout is fatal on the retry termination numbered `cfg_retry_limit`+1 within one request.
- R8: A limit value of zero disables the corresponding timeout.
- R9: Read-data parity error sets the parity bit and the detected-parity bit. Target PERR on a write sets only the parity bit. Neither ends the request: a later abort in the same request is still handled.
- R10: `req_gate` is high while the fatal bit is set, and a `req_start` seen while gated begins no request.
- R11: Status bits clear on `clr_we` with a one in `clr_mask` at bit 0 fatal, 1 master abort, 2 target abort, 3 parity, 4 detected parity. Other bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trdy_limit | input | TRDY_W | TRDY wait limit in clocks, 0 disables |
| cfg_retry_limit | input | RETRY_W | Allowed retry terminations, 0 disables |
| req_start | input | 1 | New PCI request begins |
| req_is_write | input | 1 | Direction of the starting request |
| req_done | input | 1 | Request ended normally |
| rd_pending | input | 1 | Originating system-bus read still waiting |
| wr_burst_active | input | 1 | Write burst still arriving on system bus |
| pci_devsel | input | 1 | Target has claimed the cycle (active high) |
| pci_trdy | input | 1 | Target ready (active high) |
| ev_master_abort | input | 1 | Master abort termination |
| ev_target_abort | input | 1 | Target abort termination |
| ev_retry | input | 1 | Retry termination |
| rd_parity_err | input | 1 | Parity error on read data |
| tgt_perr | input | 1 | Target signalled PERR during write |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 5 | Write-one-to-clear mask |
| bus_err_resp | output | 1 | ERROR response to pending read |
| reqq_flush | output | 1 | Flush request queue |
| txq_flush | output | 1 | Flush transmit-data queue |
| wr_drop | output | 1 | Discard remaining write beats, answer OKAY |
| req_gate | output | 1 | Block new PCI requests |
| st_fatal | output | 1 | Sticky fatal error |
| st_rma | output | 1 | Sticky received master abort |
| st_rta | output | 1 | Sticky received target abort |
| st_ppe | output | 1 | Sticky parity error |
| st_dpe | output | 1 | Sticky detected parity error |

## Verification
An internal fault shows at the ports within a small, fixed number of cycles. A stale direction latch swaps the bus error and the flush strobes one edge after the abort. An off-by-one wait or retry counter moves the fatal bit by exactly one cycle or one retry relative to the limit. A request flag that parity wrongly clears shows up because a later abort in the same request no longer sets any status. A gate that fails to hold lets an abort issued while gated set an abort bit that software had just cleared.

// File: rtl/pci_init_err_guard.sv
module pci_init_err_guard #(
  parameter int TRDY_W  = 8,
  parameter int RETRY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TRDY_W-1:0]  cfg_trdy_limit,
  input  logic [RETRY_W-1:0] cfg_retry_limit,
  input  logic               req_start,
  input  logic               req_is_write,
  input  logic               req_done,
  input  logic               rd_pending,
  input  logic               wr_burst_active,
  input  logic               pci_devsel,
  input  logic               pci_trdy,
  input  logic               ev_master_abort,
  input  logic               ev_target_abort,
  input  logic               ev_retry,
  input  logic               rd_parity_err,
  input  logic               tgt_perr,
  input  logic               clr_we,
  input  logic [4:0]         clr_mask,
  output logic               bus_err_resp,
  output logic               reqq_flush,
  output logic               txq_flush,
  output logic               wr_drop,
  output logic               req_gate,
  output logic               st_fatal,
  output logic               st_rma,
  output logic               st_rta,
  output logic               st_ppe,
  output logic               st_dpe
);
  localparam logic [TRDY_W-1:0]  T_ONE = TRDY_W'(1);
  localparam logic [TRDY_W-1:0]  T_MAX = '1;
  localparam logic [RETRY_W-1:0] R_MAX = '1;

  logic               active, cur_wr;
  logic [TRDY_W-1:0]  trdy_cnt;
  logic [RETRY_W-1:0] retry_cnt;

  wire start_ok = req_start & ~st_fatal;
  wire waiting  = active & pci_devsel & ~pci_trdy & ~ev_target_abort;
  wire trdy_to  = waiting & (cfg_trdy_limit != '0) & (trdy_cnt == cfg_trdy_limit - T_ONE);
  wire retry_to = active & ev_retry & (cfg_retry_limit != '0) & (retry_cnt == cfg_retry_limit);
  wire fatal    = active & (ev_master_abort | ev_target_abort | trdy_to | retry_to);
  wire par_rd   = active & ~cur_wr & rd_parity_err;
  wire par_wr   = active & cur_wr & tgt_perr;
  wire [4:0] clr = clr_we ? clr_mask : 5'b0;

  assign req_gate = st_fatal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cur_wr    <= 1'b0;
      trdy_cnt  <= '0;
      retry_cnt <= '0;
    end else if (start_ok) begin
      active    <= 1'b1;
      cur_wr    <= req_is_write;
      trdy_cnt  <= '0;
      retry_cnt <= '0;
    end else begin
      if (fatal | req_done) active <= 1'b0;
      if (!waiting) trdy_cnt <= '0;
      else if (trdy_cnt != T_MAX) trdy_cnt <= trdy_cnt + T_ONE;
      if (active && ev_retry && retry_cnt != R_MAX) retry_cnt <= retry_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_err_resp <= 1'b0;
      reqq_flush   <= 1'b0;
      txq_flush    <= 1'b0;
      wr_drop      <= 1'b0;
      st_fatal     <= 1'b0;
      st_rma       <= 1'b0;
      st_rta       <= 1'b0;
      st_ppe       <= 1'b0;
      st_dpe       <= 1'b0;
    end else begin
      bus_err_resp <= fatal & ~cur_wr & rd_pending;
      reqq_flush   <= fatal & cur_wr;
      txq_flush    <= fatal & cur_wr;
      wr_drop      <= wr_burst_active & ((fatal & cur_wr) | wr_drop);
      st_fatal     <= fatal | (st_fatal & ~clr[0]);
      st_rma       <= (active & ev_master_abort) | (st_rma & ~clr[1]);
      st_rta       <= (active & ev_target_abort) | (st_rta & ~clr[2]);
      st_ppe       <= par_rd | par_wr | (st_ppe & ~clr[3]);
      st_dpe       <= par_rd | (st_dpe & ~clr[4]);
    end
  end
endmodule

module pci_init_err_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_err_resp,
  input logic       reqq_flush,
  input logic       txq_flush,
  input logic       wr_drop,
  input logic       req_gate,
  input logic       st_fatal,
  input logic       st_rma,
  input logic       st_rta,
  input logic       st_ppe,
  input logic       st_dpe,
  input logic       clr_we,
  input logic [4:0] clr_mask
);
  // R3
  err_needs_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_resp |-> st_fatal);
  // R4
  flush_not_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqq_flush || txq_flush) |-> (st_fatal && !bus_err_resp));
  // R2
  abort_bit_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_rma) || $rose(st_rta)) |-> st_fatal);
  // R5
  drop_with_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_drop) |-> reqq_flush);
  // R9
  dpe_implies_ppe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_dpe) |-> st_ppe);
  // R11
  gate_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_gate) |-> $past(clr_we && clr_mask[0]));
endmodule

bind pci_init_err_guard pci_init_err_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_err_resp(bus_err_resp), .reqq_flush(reqq_flush),
  .txq_flush(txq_flush), .wr_drop(wr_drop), .req_gate(req_gate), .st_fatal(st_fatal),
  .st_rma(st_rma), .st_rta(st_rta), .st_ppe(st_ppe), .st_dpe(st_dpe),
  .clr_we(clr_we), .clr_mask(clr_mask)
);

// File: tb/tb_pci_init_err_guard.sv
module tb_pci_init_err_guard;
  logic clk = 0, rst_n = 0;
  logic [7:0] cfg_trdy_limit = 0, cfg_retry_limit = 0;
  logic req_start = 0, req_is_write = 0, req_done = 0, rd_pending = 0, wr_burst_active = 0;
  logic pci_devsel = 0, pci_trdy = 0, ev_master_abort = 0, ev_target_abort = 0, ev_retry = 0;
  logic rd_parity_err = 0, tgt_perr = 0, clr_we = 0;
  logic [4:0] clr_mask = 0;
  logic bus_err_resp, reqq_flush, txq_flush, wr_drop, req_gate;
  logic st_fatal, st_rma, st_rta, st_ppe, st_dpe;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  pci_init_err_guard dut (.*);

  wire [4:0] st = {st_dpe, st_ppe, st_rta, st_rma, st_fatal};

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_we = 1; clr_mask = 5'h1f; step();
    clr_we = 0; clr_mask = 0; step();
  endtask

  task automatic start(input logic wr);
    req_start = 1; req_is_write = wr; step();
    req_start = 0;
  endtask

  task automatic t_reset();
    chk({bus_err_resp, reqq_flush, txq_flush, wr_drop, req_gate, st}, 0, "R1 reset outputs");
  endtask

  task automatic t_read_ma_pending();
    start(0);
    rd_pending = 1; ev_master_abort = 1; step();
    ev_master_abort = 0; rd_pending = 0;
    chk(st, 5'b00011, "R2 master abort status");
    chk(bus_err_resp, 1, "R3 pending read error");
    chk(req_gate, 1, "R10 gate after fatal");
    step();
    chk(bus_err_resp, 0, "R3 error one cycle");
    clear_all();
  endtask

  task automatic t_readahead_ta();
    start(0);
    rd_pending = 0; ev_target_abort = 1; step();
    ev_target_abort = 0;
    chk(st, 5'b00101, "R2 target abort status");
    chk(bus_err_resp, 0, "R3 read-ahead silent");
    clear_all();
  endtask

  task automatic t_write_fail();
    start(1);
    wr_burst_active = 1; ev_master_abort = 1; rd_pending = 1; step();
    ev_master_abort = 0; rd_pending = 0;
    chk({reqq_flush, txq_flush, bus_err_resp}, 3'b110, "R4 write flush no error");
    chk(wr_drop, 1, "R5 drop set");
    step(2);
    chk({reqq_flush, txq_flush}, 0, "R4 flush one cycle");
    chk(wr_drop, 1, "R5 drop held");
    wr_burst_active = 0; step();
    chk(wr_drop, 0, "R5 drop released");
    clear_all();
  endtask

  task automatic t_trdy();
    cfg_trdy_limit = 4;
    start(0);
    pci_devsel = 1; step(3);
    pci_trdy = 1; step();
    pci_trdy = 0; step(3);
    chk(st_fatal, 0, "R6 trdy resets wait");
    pci_devsel = 0; req_done = 1; step(); req_done = 0;
    start(0);
    pci_devsel = 1; step(3);
    chk(st_fatal, 0, "R6 no timeout before limit");
    step();
    chk(st_fatal, 1, "R6 timeout at limit");
    pci_devsel = 0; cfg_trdy_limit = 0;
    clear_all();
  endtask

  task automatic t_retry();
    cfg_retry_limit = 2;
    start(0);
    for (int i = 0; i < 2; i++) begin ev_retry = 1; step(); ev_retry = 0; step(); end
    chk(st_fatal, 0, "R7 retries within limit");
    ev_retry = 1; step(); ev_retry = 0;
    chk(st_fatal, 1, "R7 retry over limit");
    cfg_retry_limit = 0;
    clear_all();
  endtask

  task automatic t_zero();
    start(0);
    pci_devsel = 1; step(20);
    pci_devsel = 0;
    for (int i = 0; i < 6; i++) begin ev_retry = 1; step(); ev_retry = 0; end
    chk(st_fatal, 0, "R8 zero limits disable");
    req_done = 1; step(); req_done = 0; step();
  endtask

  task automatic t_parity();
    start(0);
    rd_parity_err = 1; step(); rd_parity_err = 0;
    chk(st, 5'b11000, "R9 read parity bits");
    ev_master_abort = 1; step(); ev_master_abort = 0;
    chk(st_rma, 1, "R9 read continues after parity");
    clear_all();
    start(1);
    tgt_perr = 1; step(); tgt_perr = 0;
    chk(st, 5'b01000, "R9 write perr bit");
    ev_target_abort = 1; step(); ev_target_abort = 0;
    chk(st_rta, 1, "R9 write continues after perr");
    clear_all();
  endtask

  task automatic t_gate_clear();
    start(0);
    ev_master_abort = 1; step(); ev_master_abort = 0;
    clr_we = 1; clr_mask = 5'b00010; step(); clr_we = 0; clr_mask = 0;
    chk(st, 5'b00001, "R11 partial clear keeps fatal");
    start(0);
    ev_master_abort = 1; step(); ev_master_abort = 0; step();
    chk(st_rma, 0, "R10 gated start ignored");
    clr_we = 1; clr_mask = 5'b00001; step(); clr_we = 0; clr_mask = 0;
    chk({req_gate, st_fatal}, 0, "R11 fatal clear reopens gate");
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1; step();
    t_reset();
    t_read_ma_pending();
    t_readahead_ta();
    t_write_fail();
    t_trdy();
    t_retry();
    t_zero();
    t_parity();
    t_gate_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule